// File: doc/BRIEF.md
# Sequential RGB Palette Load Port

This block is the register side of a colour lookup table for an indexed-colour display pipe. Software first writes an entry number to the index port. It then writes three bytes to the data port: the red component, the green component and the blue component of that entry. Each component is six bits wide. A three-phase sequencer behind the data port keeps the first two components in staging registers. When the blue byte arrives, the full 18-bit colour is written into the table in one step, and the entry pointer moves on by one. Software can therefore stream a whole palette after a single index write.

The pixel side presents an entry number on the lookup port and gets back the stored 18-bit colour one clock later. To blank the screen, software loads zero into all three components of each of the first sixteen entries.

Top module: `palette_dac_port`

## Requirements
- R1: Synchronous active-high reset clears `pix_rgb` to zero, sets the component phase to red and sets the entry pointer to 0. A triplet written after reset with no index write therefore lands in entry 0.
- R2: A pulse on `idx_we` loads `idx_wdata` into the entry pointer. The next complete triplet is stored at that entry.
- R3: Data bytes are taken in the order red, green, blue. The stored colour is packed as red in bits 17:12, green in bits 11:6 and blue in bits 5:0.
- R4: An entry keeps its old value after its red and green components have been written. It changes only when the blue component is written, and then all three fields change together.
- R5: After each complete triplet the entry pointer increments by one, so back-to-back triplets fill consecutive entries.
- R6: The entry pointer wraps from the last entry (ENTRIES-1) to entry 0.
- R7: An index write in the middle of a triplet discards the staged components and returns the phase to red.
- R8: Bits 7:6 of each data byte have no effect on the stored colour.
- R9: When `idx_we` and `dat_we` are both high in the same cycle, the index write takes effect and the data byte is dropped.
- R10: `pix_rgb` shows, one clock later, the entry addressed by `pix_idx`. Lookups issued in consecutive cycles return their results in consecutive cycles.
- R11: In cycles with neither `idx_we` nor `dat_we` high, the entry pointer and the component phase keep their values.
- R12: Writing 48 zero bytes after setting the pointer to entry 0 makes entries 0 to 15 read back zero. Entry 16 is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idx_we | input | 1 | Index port write strobe |
| idx_wdata | input | IDX_W (8) | Entry number to select |
| dat_we | input | 1 | Data port write strobe |
| dat_wdata | input | BUS_W (8) | Colour component byte; the low COMP_W bits are used |
| pix_idx | input | IDX_W (8) | Entry number to look up |
| pix_rgb | output | 3*COMP_W (18) | Registered colour of the looked-up entry |

## Verification
The assertions check the sequencer on every cycle:
- an index write loads the pointer and restarts the phase at red (R2);
- a red byte moves the phase to green (R3);
- a blue byte advances the pointer with wrap (R5, R6);
- idle cycles hold the pointer and the phase (R11).

Only the bench scenarios, read back through the lookup port, can show the rest:
- the field packing and the one-cycle lookup latency;
- that staged components stay invisible until blue arrives;
- that an interrupted triplet and the high data bits leave nothing behind;
- that the blanking sequence clears exactly the first sixteen entries.

// File: rtl/pal_pkg.sv
`timescale 1ns/1ps
package pal_pkg;
  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;
endpackage

// File: rtl/pal_load_seq.sv
`timescale 1ns/1ps
module pal_load_seq
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 6,
  parameter int BUS_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RGB_W  = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic             dat_we,
  input  logic [BUS_W-1:0] dat_wdata,
  output logic             commit_o,
  output logic [IDX_W-1:0] commit_idx_o,
  output logic [RGB_W-1:0] commit_rgb_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  phase_e             phase_q;
  logic [IDX_W-1:0]   idx_q;
  logic [COMP_W-1:0]  stg_r_q, stg_g_q;
  logic [COMP_W-1:0]  comp;
  logic               dat_take;
  logic [IDX_W-1:0]   idx_next;
  logic               unused_hi;

  // Only the low bits of a data byte carry a component.
  assign comp      = dat_wdata[COMP_W-1:0];
  assign unused_hi = ^dat_wdata[BUS_W-1:COMP_W];

  // An index write wins over a data write in the same cycle.
  assign dat_take  = dat_we && !idx_we;
  assign idx_next  = (idx_q == LAST) ? '0 : idx_q + 1'b1;

  assign commit_o     = dat_take && (phase_q == PH_BLU);
  assign commit_idx_o = idx_q;
  assign commit_rgb_o = {stg_r_q, stg_g_q, comp};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_RED;
      idx_q   <= '0;
      stg_r_q <= '0;
      stg_g_q <= '0;
    end else if (idx_we) begin
      phase_q <= PH_RED;
      idx_q   <= idx_wdata;
    end else if (dat_take) begin
      unique case (phase_q)
        PH_RED: begin
          stg_r_q <= comp;
          phase_q <= PH_GRN;
        end
        PH_GRN: begin
          stg_g_q <= comp;
          phase_q <= PH_BLU;
        end
        default: begin
          phase_q <= PH_RED;
          idx_q   <= idx_next;
        end
      endcase
    end
  end

  p_idx_load_r2: assert property (@(posedge clk) disable iff (rst)
    idx_we |=> (idx_q == $past(idx_wdata)) && (phase_q == PH_RED));

  p_red_to_green_r3: assert property (@(posedge clk) disable iff (rst)
    (dat_we && !idx_we && phase_q == PH_RED) |=> (phase_q == PH_GRN));

  // R5 and R6: the pointer advances after blue and wraps at the last entry.
  p_advance_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (dat_we && !idx_we && phase_q == PH_BLU) |=>
      (phase_q == PH_RED) &&
      (idx_q == (($past(idx_q) == LAST) ? '0 : $past(idx_q) + 1'b1)));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (!dat_we && !idx_we) |=> $stable(idx_q) && $stable(phase_q));
endmodule

// File: rtl/pal_ram.sv
`timescale 1ns/1ps
module pal_ram #(
  parameter int DEPTH  = 256,
  parameter int WIDTH  = 18,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // Write port: no reset, so the array maps onto block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read with a resettable output register.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/palette_dac_port.sv
`timescale 1ns/1ps
module palette_dac_port #(
  parameter int ENTRIES = 256,
  parameter int COMP_W  = 6,
  parameter int BUS_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int RGB_W  = 3 * COMP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idx_we,
  input  logic [IDX_W-1:0] idx_wdata,
  input  logic             dat_we,
  input  logic [BUS_W-1:0] dat_wdata,
  input  logic [IDX_W-1:0] pix_idx,
  output logic [RGB_W-1:0] pix_rgb
);
  logic             cm_we;
  logic [IDX_W-1:0] cm_idx;
  logic [RGB_W-1:0] cm_rgb;

  pal_load_seq #(
    .ENTRIES(ENTRIES), .COMP_W(COMP_W), .BUS_W(BUS_W)
  ) u_seq (
    .clk(clk), .rst(rst),
    .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .commit_o(cm_we), .commit_idx_o(cm_idx), .commit_rgb_o(cm_rgb)
  );

  pal_ram #(
    .DEPTH(ENTRIES), .WIDTH(RGB_W)
  ) u_ram (
    .clk(clk), .rst(rst),
    .we(cm_we), .waddr(cm_idx), .wdata(cm_rgb),
    .raddr(pix_idx), .rdata(pix_rgb)
  );

  // R1: reset clears the lookup output on the next edge.
  p_reset_out_r1: assert property (@(posedge clk)
    rst |=> (pix_rgb == '0));
endmodule

// File: tb/test_palette_dac_port.sv
`timescale 1ns/1ps
module test_palette_dac_port;
  localparam int N = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        idx_we = 1'b0;
  logic [7:0]  idx_wdata = '0;
  logic        dat_we = 1'b0;
  logic [7:0]  dat_wdata = '0;
  logic [7:0]  pix_idx = '0;
  logic [17:0] pix_rgb;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  typedef struct {
    logic [17:0] exp;
    int          due;
    string       tag;
  } item_t;
  item_t q[$];

  // Reference model built from the requirements.
  logic [17:0] m_mem [N];
  logic [7:0]  m_idx = '0;
  int          m_ph = 0;
  logic [5:0]  m_r = '0, m_g = '0;

  palette_dac_port i_palette_dac_port (
    .clk(clk), .rst(rst),
    .idx_we(idx_we), .idx_wdata(idx_wdata),
    .dat_we(dat_we), .dat_wdata(dat_wdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: pops the expected item that falls due in this cycle.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (pix_rgb !== it.exp) begin
        errors++;
        $display("FAIL %s: pix_rgb=%h expected=%h", it.tag, pix_rgb, it.exp);
      end
    end
  end

  task automatic wr_idx(input logic [7:0] v);
    @(posedge clk); #1;
    idx_we = 1'b1; idx_wdata = v;
    m_idx = v; m_ph = 0;
    @(posedge clk); #1;
    idx_we = 1'b0;
  endtask

  task automatic model_dat(input logic [7:0] v);
    case (m_ph)
      0: begin m_r = v[5:0]; m_ph = 1; end
      1: begin m_g = v[5:0]; m_ph = 2; end
      default: begin
        m_mem[m_idx] = {m_r, m_g, v[5:0]};
        m_idx = m_idx + 8'd1;
        m_ph = 0;
      end
    endcase
  endtask

  task automatic wr_dat(input logic [7:0] v);
    @(posedge clk); #1;
    dat_we = 1'b1; dat_wdata = v;
    model_dat(v);
    @(posedge clk); #1;
    dat_we = 1'b0;
  endtask

  task automatic wr_both(input logic [7:0] iv, input logic [7:0] dv);
    @(posedge clk); #1;
    idx_we = 1'b1; idx_wdata = iv;
    dat_we = 1'b1; dat_wdata = dv;
    m_idx = iv; m_ph = 0;
    @(posedge clk); #1;
    idx_we = 1'b0; dat_we = 1'b0;
  endtask

  task automatic triplet(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
    wr_dat(r); wr_dat(g); wr_dat(b);
  endtask

  // Driver: issues a lookup and queues the expected colour.
  task automatic look(input logic [7:0] i, input string tag);
    item_t it;
    @(posedge clk); #1;
    pix_idx = i;
    it.exp = m_mem[i]; it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic look_val(input logic [7:0] i, input logic [17:0] v, input string tag);
    item_t it;
    @(posedge clk); #1;
    pix_idx = i;
    it.exp = v; it.due = cyc + 1; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (pix_rgb !== 18'd0) begin
      errors++;
      $display("FAIL R1: reset pix_rgb=%h expected=0", pix_rgb);
    end
    @(posedge clk); #1;
    rst = 1'b0;

    // R1: with no index write, the first triplet lands in entry 0.
    triplet(8'd1, 8'd2, 8'd3);
    look_val(8'd0, {6'd1, 6'd2, 6'd3}, "R1");
    look(8'd0, "R3");

    // R5/R6: fill the whole table, then one more triplet wraps to entry 0.
    wr_idx(8'd0);
    for (int i = 0; i < N; i++)
      triplet(8'(i & 63), 8'((i * 3) & 63), 8'((255 - i) & 63));
    triplet(8'h15, 8'h2A, 8'h3F);
    look_val(8'd0, {6'h15, 6'h2A, 6'h3F}, "R6");
    look(8'd1,   "R5");
    look(8'd100, "R5");
    look(8'd255, "R6");

    // R10: back-to-back lookups return in consecutive cycles.
    look(8'd10, "R10");
    look(8'd11, "R10");
    look(8'd12, "R10");

    // R2: an explicit index write steers the next triplet.
    wr_idx(8'd42);
    triplet(8'h3E, 8'h01, 8'h20);
    look_val(8'd42, {6'h3E, 6'h01, 6'h20}, "R2");

    // R4: red and green alone leave the entry unchanged.
    wr_idx(8'd7);
    wr_dat(8'h11); wr_dat(8'h22);
    look(8'd7, "R4");
    wr_dat(8'h33);
    look_val(8'd7, {6'h11, 6'h22, 6'h33}, "R4");
    look(8'd8, "R4");

    // R7: an index write mid-triplet discards the staged components.
    wr_idx(8'd9);
    wr_dat(8'h05); wr_dat(8'h06);
    wr_idx(8'd9);
    triplet(8'h2B, 8'h2C, 8'h2D);
    look_val(8'd9, {6'h2B, 6'h2C, 6'h2D}, "R7");
    triplet(8'h01, 8'h01, 8'h01);
    look(8'd10, "R7");

    // R8: bits 7:6 of each data byte are dropped.
    wr_idx(8'd30);
    triplet(8'hFF, 8'hC0, 8'h81);
    look_val(8'd30, {6'h3F, 6'h00, 6'h01}, "R8");

    // R9: a simultaneous index and data write keeps only the index.
    wr_both(8'd20, 8'h3F);
    triplet(8'h04, 8'h08, 8'h0C);
    look_val(8'd20, {6'h04, 6'h08, 6'h0C}, "R9");
    look(8'd21, "R9");

    // R12: the blanking sequence clears entries 0..15 only.
    wr_idx(8'd0);
    for (int i = 0; i < 48; i++) wr_dat(8'h00);
    for (int i = 0; i < 16; i++) look_val(8'(i), 18'd0, "R12");
    look(8'd16, "R12");

    while (q.size() != 0) @(negedge clk);
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, pending=%0d expected=0", q.size());
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule